// File: doc/BRIEF.md
# Bidirectional Doorbell Interrupt Registers

This block holds two doorbell registers that let a local processor and a remote bus agent interrupt each other. The outbound doorbell is raised by the local side and serviced by the remote side. The inbound doorbell carries requests the other way. A raiser writes a mask in which every 1 sets the matching doorbell bit. The servicer reads the register, handles the request and writes a mask in which every 1 clears the matching bit. Bits written as 0 are left unchanged in both cases.

Each direction drives its own interrupt. The remote-facing interrupt is active low and the local-facing interrupt is active high. Each interrupt is qualified by its own enable and is registered, so it follows the doorbell contents one clock later. A test-mode input lets the local side write either register as a plain read/write register, so that software can preload patterns.

Both register values are presented on output ports, which serves reads from either side. Both access ports are in one clock domain. Address decoding and bus protocol are left to the surrounding logic.

Top module: `doorbell_pair`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both doorbells read 0, `rem_irq_n` is 1 and `loc_irq` is 0.
- R2: Outbound doorbell (select value 0): a local write with `test_mode`=0 sets every bit that is 1 in the data and leaves the other bits unchanged.
- R3: Outbound doorbell: a remote write with select 0 clears every bit that is 1 in the data and leaves the other bits unchanged.
- R4: Inbound doorbell (select value 1): a remote write sets the bits that are 1 in the data, and a local write with `test_mode`=0 clears the bits that are 1 in the data.
- R5: When the setting side and the clearing side write the same doorbell in one cycle, the new value is (old AND NOT clear-mask) OR set-mask, so a set wins on any bit that both sides target.
- R6: While `test_mode`=1, a local write loads its data into the selected doorbell unchanged. A remote write to that same doorbell in that cycle has no effect.
- R7: `rem_irq_n` is 0 in the cycle after one in which the outbound doorbell is nonzero and `out_irq_en`=1. Otherwise it is 1.
- R8: `loc_irq` is 1 in the cycle after one in which the inbound doorbell is nonzero and `in_irq_en`=1. Otherwise it is 0.
- R9: Dropping an enable removes its interrupt one clock later and leaves the stored doorbell bits unchanged.
- R10: A write selecting one doorbell leaves the other doorbell unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1 = local writes load the selected doorbell directly |
| loc_wr_en | input | 1 | Local-side write strobe |
| loc_wr_sel | input | 1 | Local target: 0 outbound, 1 inbound |
| loc_wr_data | input | WIDTH | Local write mask or value |
| rem_wr_en | input | 1 | Remote-side write strobe |
| rem_wr_sel | input | 1 | Remote target: 0 outbound, 1 inbound |
| rem_wr_data | input | WIDTH | Remote write mask |
| out_irq_en | input | 1 | Enable for the remote-facing interrupt |
| in_irq_en | input | 1 | Enable for the local-facing interrupt |
| bell_to_rem | output | WIDTH | Outbound doorbell contents, read by both sides |
| bell_to_loc | output | WIDTH | Inbound doorbell contents, read by both sides |
| rem_irq_n | output | 1 | Remote-facing interrupt, active low |
| loc_irq | output | 1 | Local-facing interrupt, active high |

## Verification
The set from one side and the clear from the other side can hit the same doorbell in the same clock. With a 4-bit configuration, the bench preloads every starting value through test mode and then applies every combination of set mask and clear mask in a single cycle, to both doorbells. Each result is judged against the masked formula computed in the bench. Test-mode loads that collide with a remote write are swept the same way. The bench expects the load value to replace the register outright.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  // Target selector carried on both write ports.
  typedef enum logic {
    BELL_TO_REM = 1'b0,
    BELL_TO_LOC = 1'b1
  } bell_sel_e;

  localparam int NUM_BELLS = 2;
endpackage

// File: rtl/doorbell_bits.sv
module doorbell_bits #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_vld,
  input  logic [WIDTH-1:0] set_mask,
  input  logic             clr_vld,
  input  logic [WIDTH-1:0] clr_mask,
  input  logic             load_vld,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] bell_q
);
  logic [WIDTH-1:0] bell_d;
  logic [WIDTH-1:0] eff_set;
  logic [WIDTH-1:0] eff_clr;
  logic             bell_ce;

  always_comb begin
    eff_set = set_vld ? set_mask : '0;
    eff_clr = clr_vld ? clr_mask : '0;
    bell_ce = set_vld | clr_vld | load_vld;
    if (load_vld) begin
      bell_d = load_val;
    end else begin
      // a set outranks a clear on shared bits
      bell_d = (bell_q & ~eff_clr) | eff_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bell_q <= '0;
    end else if (bell_ce) begin
      bell_q <= bell_d;
    end
  end
endmodule

// File: rtl/doorbell_irq.sv
module doorbell_irq #(
  parameter int WIDTH      = 32,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] bell_q,
  input  logic             irq_en,
  output logic             irq_pin
);
  logic pend_d;
  logic pend_q;
  logic pend_ce;

  always_comb begin
    pend_d  = irq_en & (|bell_q);
    pend_ce = pend_d ^ pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

  generate
    if (ACTIVE_LOW) begin : g_low
      assign irq_pin = ~pend_q;
    end else begin : g_high
      assign irq_pin = pend_q;
    end
  endgenerate
endmodule

// File: rtl/doorbell_pair.sv
module doorbell_pair
  import doorbell_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             loc_wr_en,
  input  logic             loc_wr_sel,
  input  logic [WIDTH-1:0] loc_wr_data,
  input  logic             rem_wr_en,
  input  logic             rem_wr_sel,
  input  logic [WIDTH-1:0] rem_wr_data,
  input  logic             out_irq_en,
  input  logic             in_irq_en,
  output logic [WIDTH-1:0] bell_to_rem,
  output logic [WIDTH-1:0] bell_to_loc,
  output logic             rem_irq_n,
  output logic             loc_irq
);
  logic [WIDTH-1:0] bell_q [NUM_BELLS];
  logic             irq_en_v [NUM_BELLS];
  logic             irq_pin_v [NUM_BELLS];

  assign irq_en_v[0] = out_irq_en;
  assign irq_en_v[1] = in_irq_en;

  genvar g;
  generate
    for (g = 0; g < NUM_BELLS; g++) begin : g_bell
      localparam bell_sel_e SEL = bell_sel_e'(g);
      logic loc_hit;
      logic rem_hit;
      logic set_vld;
      logic clr_vld;
      logic load_vld;
      logic [WIDTH-1:0] set_mask;
      logic [WIDTH-1:0] clr_mask;

      always_comb begin
        loc_hit  = loc_wr_en & (bell_sel_e'(loc_wr_sel) == SEL);
        rem_hit  = rem_wr_en & (bell_sel_e'(rem_wr_sel) == SEL);
        load_vld = loc_hit & test_mode;
      end

      if (SEL == BELL_TO_REM) begin : g_loc_raises
        always_comb begin
          set_vld  = loc_hit & ~test_mode;
          set_mask = loc_wr_data;
          clr_vld  = rem_hit;
          clr_mask = rem_wr_data;
        end
      end else begin : g_rem_raises
        always_comb begin
          set_vld  = rem_hit;
          set_mask = rem_wr_data;
          clr_vld  = loc_hit & ~test_mode;
          clr_mask = loc_wr_data;
        end
      end

      doorbell_bits #(.WIDTH(WIDTH)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (set_vld),
        .set_mask (set_mask),
        .clr_vld  (clr_vld),
        .clr_mask (clr_mask),
        .load_vld (load_vld),
        .load_val (loc_wr_data),
        .bell_q   (bell_q[g])
      );

      doorbell_irq #(
        .WIDTH      (WIDTH),
        .ACTIVE_LOW (SEL == BELL_TO_REM)
      ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .bell_q  (bell_q[g]),
        .irq_en  (irq_en_v[g]),
        .irq_pin (irq_pin_v[g])
      );
    end
  endgenerate

  assign bell_to_rem = bell_q[0];
  assign bell_to_loc = bell_q[1];
  assign rem_irq_n   = irq_pin_v[0];
  assign loc_irq     = irq_pin_v[1];
endmodule

// File: rtl/doorbell_pair_chk.sv
module doorbell_pair_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_mode,
  input logic             loc_wr_en,
  input logic             loc_wr_sel,
  input logic [WIDTH-1:0] loc_wr_data,
  input logic             rem_wr_en,
  input logic             rem_wr_sel,
  input logic [WIDTH-1:0] rem_wr_data,
  input logic             out_irq_en,
  input logic             in_irq_en,
  input logic [WIDTH-1:0] bell_to_rem,
  input logic [WIDTH-1:0] bell_to_loc,
  input logic             rem_irq_n,
  input logic             loc_irq
);
  // R2
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr_en && !loc_wr_sel && !test_mode && !(rem_wr_en && !rem_wr_sel))
    |=> (bell_to_rem == ($past(bell_to_rem) | $past(loc_wr_data))));

  // R3
  out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_wr_en && !rem_wr_sel && !(loc_wr_en && !loc_wr_sel))
    |=> (bell_to_rem == ($past(bell_to_rem) & ~$past(rem_wr_data))));

  // R4
  in_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_wr_en && rem_wr_sel && !(loc_wr_en && loc_wr_sel))
    |=> (bell_to_loc == ($past(bell_to_loc) | $past(rem_wr_data))));

  // R6
  test_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && loc_wr_en && loc_wr_sel)
    |=> (bell_to_loc == $past(loc_wr_data)));

  // R7
  rem_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rem_irq_n == !($past(out_irq_en) && (|$past(bell_to_rem)))));

  // R8
  loc_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (loc_irq == ($past(in_irq_en) && (|$past(bell_to_loc)))));

  // R10
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((loc_wr_en && !loc_wr_sel) || (rem_wr_en && !rem_wr_sel))
    |=> $stable(bell_to_rem));
endmodule

bind doorbell_pair doorbell_pair_chk #(.WIDTH(WIDTH)) u_doorbell_pair_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .test_mode   (test_mode),
  .loc_wr_en   (loc_wr_en),
  .loc_wr_sel  (loc_wr_sel),
  .loc_wr_data (loc_wr_data),
  .rem_wr_en   (rem_wr_en),
  .rem_wr_sel  (rem_wr_sel),
  .rem_wr_data (rem_wr_data),
  .out_irq_en  (out_irq_en),
  .in_irq_en   (in_irq_en),
  .bell_to_rem (bell_to_rem),
  .bell_to_loc (bell_to_loc),
  .rem_irq_n   (rem_irq_n),
  .loc_irq     (loc_irq)
);

// File: tb/test_doorbell_pair.sv
module test_doorbell_pair;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         test_mode;
  logic         loc_wr_en, loc_wr_sel, rem_wr_en, rem_wr_sel;
  logic [W-1:0] loc_wr_data, rem_wr_data;
  logic         out_irq_en, in_irq_en;
  logic [W-1:0] bell_to_rem, bell_to_loc;
  logic         rem_irq_n, loc_irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] m_out, m_in;
  logic         m_rirq, m_lirq;

  always #5 clk = ~clk;

  doorbell_pair #(.WIDTH(W)) i_doorbell_pair (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .loc_wr_en(loc_wr_en), .loc_wr_sel(loc_wr_sel), .loc_wr_data(loc_wr_data),
    .rem_wr_en(rem_wr_en), .rem_wr_sel(rem_wr_sel), .rem_wr_data(rem_wr_data),
    .out_irq_en(out_irq_en), .in_irq_en(in_irq_en),
    .bell_to_rem(bell_to_rem), .bell_to_loc(bell_to_loc),
    .rem_irq_n(rem_irq_n), .loc_irq(loc_irq)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mnext(input int r, input logic [W-1:0] q,
      input logic le, input logic ls, input logic [W-1:0] ld,
      input logic re, input logic rs, input logic [W-1:0] rd, input logic tm);
    logic [W-1:0] s, c;
    s = '0;
    c = '0;
    if (tm && le && (int'(ls) == r)) return ld;
    if (r == 0) begin
      if (le && !ls && !tm) s = ld;
      if (re && !rs) c = rd;
    end else begin
      if (re && rs) s = rd;
      if (le && ls && !tm) c = ld;
    end
    return (q & ~c) | s;
  endfunction

  // One clock: drive after the falling edge, compare at the next falling edge.
  task automatic step(input logic le, input logic ls, input logic [W-1:0] ld,
      input logic re, input logic rs, input logic [W-1:0] rd,
      input logic tm, input logic oe, input logic ie,
      input string tag_o, input string tag_i);
    m_rirq = !(oe && (|m_out));
    m_lirq = ie && (|m_in);
    m_out  = mnext(0, m_out, le, ls, ld, re, rs, rd, tm);
    m_in   = mnext(1, m_in,  le, ls, ld, re, rs, rd, tm);
    loc_wr_en = le; loc_wr_sel = ls; loc_wr_data = ld;
    rem_wr_en = re; rem_wr_sel = rs; rem_wr_data = rd;
    test_mode = tm; out_irq_en = oe; in_irq_en = ie;
    @(posedge clk);
    @(negedge clk);
    chk(tag_o, bell_to_rem, m_out);
    chk(tag_i, bell_to_loc, m_in);
    chk("R7 rem_irq_n", {{(W-1){1'b0}}, rem_irq_n}, {{(W-1){1'b0}}, m_rirq});
    chk("R8 loc_irq",   {{(W-1){1'b0}}, loc_irq},   {{(W-1){1'b0}}, m_lirq});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; test_mode = 1'b0;
    loc_wr_en = 1'b0; loc_wr_sel = 1'b0; loc_wr_data = '0;
    rem_wr_en = 1'b0; rem_wr_sel = 1'b0; rem_wr_data = '0;
    out_irq_en = 1'b1; in_irq_en = 1'b1;
    m_out = '0; m_in = '0;
    repeat (3) @(negedge clk);
    // R1: values held during reset
    chk("R1 out", bell_to_rem, '0);
    chk("R1 in", bell_to_loc, '0);
    chk("R1 rem_irq_n", {{(W-1){1'b0}}, rem_irq_n}, {{(W-1){1'b0}}, 1'b1});
    chk("R1 loc_irq", {{(W-1){1'b0}}, loc_irq}, '0);
    rst_n = 1'b1;
    step(0, 0, '0, 0, 0, '0, 0, 1, 1, "R1 out", "R1 in");

    // R2 / R3 / R4 sweeps: preload through test mode, then one operation
    for (int a = 0; a < N; a++) begin
      for (int d = 0; d < N; d++) begin
        logic oe, ie;
        oe = a[0] ^ d[1];
        ie = a[1] ^ d[0];
        step(1, 0, W'(a), 0, 0, '0, 1, oe, ie, "R6 out", "R10 in");
        step(1, 0, W'(d), 0, 0, '0, 0, oe, ie, "R2 out set", "R10 in");
        step(1, 0, W'(a), 0, 0, '0, 1, oe, ie, "R6 out", "R10 in");
        step(0, 0, '0, 1, 0, W'(d), 0, oe, ie, "R3 out clr", "R10 in");
        step(1, 1, W'(a), 0, 0, '0, 1, oe, ie, "R10 out", "R6 in");
        step(0, 0, '0, 1, 1, W'(d), 0, oe, ie, "R10 out", "R4 in set");
        step(1, 1, W'(a), 0, 0, '0, 1, oe, ie, "R10 out", "R6 in");
        step(1, 1, W'(d), 0, 0, '0, 0, oe, ie, "R10 out", "R4 in clr");
      end
    end

    // R5: same-cycle set and clear on one doorbell, all masks
    for (int a = 0; a < N; a++) begin
      for (int s = 0; s < N; s++) begin
        for (int c = 0; c < N; c++) begin
          step(1, 0, W'(a), 0, 0, '0, 1, 1, 1, "R6 out", "R10 in");
          step(1, 0, W'(s), 1, 0, W'(c), 0, 1, 1, "R5 out", "R10 in");
          step(1, 1, W'(a), 0, 0, '0, 1, 1, 1, "R10 out", "R6 in");
          step(1, 1, W'(c), 1, 1, W'(s), 0, 1, 1, "R10 out", "R5 in");
        end
      end
    end

    // R6: test-mode load collides with a remote write to the same doorbell
    for (int a = 0; a < N; a++) begin
      for (int d = 0; d < N; d++) begin
        step(1, 0, W'(a), 1, 0, W'(d), 1, 1, 1, "R6 out collide", "R10 in");
        step(1, 1, W'(a), 1, 1, W'(d), 1, 1, 1, "R10 out", "R6 in collide");
      end
    end

    // R9: mask both interrupts, bits stay, then unmask again
    step(1, 0, 4'h5, 1, 1, 4'hA, 0, 1, 1, "R2 out", "R4 in");
    step(0, 0, '0, 0, 0, '0, 0, 1, 1, "R9 out", "R9 in");
    step(0, 0, '0, 0, 0, '0, 0, 0, 0, "R9 out held", "R9 in held");
    step(0, 0, '0, 0, 0, '0, 0, 0, 0, "R9 out held", "R9 in held");
    step(0, 0, '0, 0, 0, '0, 0, 1, 1, "R9 out held", "R9 in held");
    step(0, 0, '0, 0, 0, '0, 0, 1, 1, "R9 out", "R9 in");
    // servicing clears drop the interrupts
    step(0, 0, '0, 1, 0, 4'hF, 0, 1, 1, "R3 out", "R10 in");
    step(1, 1, 4'hF, 0, 0, '0, 0, 1, 1, "R10 out", "R4 in");
    step(0, 0, '0, 0, 0, '0, 0, 1, 1, "R7 out", "R8 in");
    finish_run();
  end
endmodule